// File: doc/BRIEF.md
# Decode Group Steering with Microcode Escape

This block sits between a pre-decoded instruction window and the register renaming stage. Every instruction in the window has already had its length found. Each one carries a small count of the micro-operations it turns into. Each cycle the block builds one decode group and presents up to four micro-operation slots, in program order, to the rename stage.

The decoders are asymmetric. Only the leading instruction of a group may expand to several micro-operations, between one and four. Every later member of the group must expand to exactly one. A non-leading instruction that needs more than one micro-operation ends the group early and leads the group in the next cycle. An instruction whose count field marks it as too large for the leading decoder goes to a microcode stub instead. The stub streams that instruction's micro-operations over as many cycles as needed and holds normal decode off until it has finished.

The window shows up to four entries as a valid prefix. The block returns how many entries it consumed. A single ready from the consumer gates every state change.

Top module: `uop_group_steer`

## Requirements
- R1: After reset, with an empty window, no slot is valid, `q_pop` is 0 and `uop_ucode` is 0.
- R2: When the leading entry's count field (entry i at `q_cnt[3i+:3]`) holds c in 1..4, slots 0..c-1 are valid with source index 0 (`uop_src[2k+:2]`) and sequence numbers 0..c-1 (`uop_seq[6k+:6]`).
- R3: Following entries with count 1 fill the remaining slots in window order. Each carries its own window index as source and sequence 0, and the group never exceeds four micro-operations.
- R4: The group stops at the first non-leading entry that is absent or has a count other than 1, counts of 5 to 7 included. That entry is not consumed.
- R5: With `uop_ready` high, `q_pop` equals the number of instructions in the group. It never exceeds the number of valid entries.
- R6: With `uop_ready` low, `q_pop` is 0 and no internal state changes. The same slots are presented again in the next cycle.
- R7: A leading entry with count 5 to 7 is handed to the microcode stub. In that cycle no slot is valid and `q_pop` is 1. The stream length is taken from that entry's length field `q_mlen[6i+:6]`.
- R8: While the stub streams, it emits min(4, remaining) micro-operations per cycle with `uop_ucode` high. Its sequence numbers run on across cycles, and `q_pop` stays 0 whatever the window holds.
- R9: In the cycle after the last streamed micro-operation is accepted, normal group decode resumes.
- R10: The slot valid mask is always a prefix, contiguous from slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_vld | input | 4 | Window entry present, as a prefix from entry 0 |
| q_cnt | input | 12 | Micro-op count per entry, 3 bits each; 5..7 means microcode |
| q_mlen | input | 24 | Microcode stream length per entry, 6 bits each |
| q_pop | output | 3 | Number of window entries consumed this cycle |
| uop_ready | input | 1 | Consumer accepts the slots; low freezes the block |
| uop_vld | output | 4 | Slot valid mask |
| uop_src | output | 8 | Per-slot source window index, 2 bits each |
| uop_seq | output | 24 | Per-slot micro-op number within its instruction, 6 bits each |
| uop_ucode | output | 1 | Slots come from the microcode stub |

## Verification
The bench drives four different windows:
- all-simple;
- a leading entry of width 3 followed by simples;
- a leading entry of width 4 followed by simples;
- a short window of two entries.

Together these separate leading-slot expansion from the filling of the remaining slots. Windows with a multi-op or microcode entry in a later position show whether the group is cut at the right instruction and whether that instruction is left unconsumed.

Two stream lengths are run through the microcode stub. Length 10 ends in a partial final beat. Length 4 fills exactly one beat. These expose off-by-one errors at the hand-back to normal decode. A stall in the middle of a stream and a stall during normal decode show that a low ready freezes both the counter and the consumption.

// File: rtl/ugs_pkg.sv
// Package: shared constants for decode group steering.
// Assumes: count fields are 3 bits wide; values at or above UC_MIN escape to microcode.
package ugs_pkg;
    localparam int CNT_W  = 3;
    localparam int UC_MIN = 5;
endpackage

// File: rtl/ugs_group_former.sv
// Module: ugs_group_former
// Builds one decode group from the window. The leading entry expands to
// its count; later single-op entries fill the remaining slots in order.
// Assumes: q_vld is a prefix; a count of 0 is treated as 1.
module ugs_group_former
    import ugs_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int MLW   = 6,
    localparam int SRC_W = $clog2(SLOTS),
    localparam int NI_W  = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0]       q_vld,
    input  logic [SLOTS*CNT_W-1:0] q_cnt,
    output logic [SLOTS-1:0]       g_vld,
    output logic [SLOTS*SRC_W-1:0] g_src,
    output logic [SLOTS*MLW-1:0]   g_seq,
    output logic [NI_W-1:0]        g_ninstr,
    output logic                   g_uc
);
    logic [CNT_W-1:0] lead;
    assign lead = q_cnt[CNT_W-1:0];

    // Purpose: steer leading expansion then single-op followers into slots.
    always_comb begin
        int lead_n;
        int pos;
        int ninstr;
        logic open;
        g_vld    = '0;
        g_src    = '0;
        g_seq    = '0;
        g_ninstr = '0;
        g_uc     = 1'b0;
        lead_n   = (lead == '0) ? 1 : int'(lead);
        pos      = 0;
        ninstr   = 0;
        open     = 1'b1;
        if (q_vld[0]) begin
            if (int'(lead) >= UC_MIN) begin
                g_uc   = 1'b1;
                ninstr = 1;
            end else begin
                for (int k = 0; k < SLOTS; k++) begin
                    if (k < lead_n) begin
                        g_vld[k]            = 1'b1;
                        g_seq[k*MLW +: MLW] = MLW'(k);
                    end
                end
                pos    = lead_n;
                ninstr = 1;
                for (int i = 1; i < SLOTS; i++) begin
                    if (open && q_vld[i] && (q_cnt[i*CNT_W +: CNT_W] <= CNT_W'(1))
                        && (pos < SLOTS)) begin
                        g_vld[pos]                = 1'b1;
                        g_src[pos*SRC_W +: SRC_W] = SRC_W'(i);
                        pos                       = pos + 1;
                        ninstr                    = ninstr + 1;
                    end else begin
                        open = 1'b0;
                    end
                end
            end
        end
        g_ninstr = NI_W'(ninstr);
    end

    // R3: a group never names more instructions than it has valid slots
    always_comb begin
        a_r3_ninstr_fits: assert (g_uc || (int'(g_ninstr) <= $countones(g_vld)));
    end
endmodule

// File: rtl/ugs_ucode_seq.sv
// Module: ugs_ucode_seq
// Microcode stub: once loaded with a length, streams up to SLOTS
// micro-op numbers per accepted cycle until the length is used up.
// Assumes: advance low means the consumer stalls; nothing moves then.
module ugs_ucode_seq #(
    parameter int SLOTS = 4,
    parameter int MLW   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 advance,
    input  logic                 start,
    input  logic [MLW-1:0]       start_len,
    output logic                 busy,
    output logic [SLOTS-1:0]     s_vld,
    output logic [SLOTS*MLW-1:0] s_seq
);
    localparam logic [MLW-1:0] SLOTS_L = MLW'(SLOTS);

    logic [MLW-1:0] left_q;
    logic [MLW-1:0] idx_q;
    logic [MLW-1:0] beat;

    assign busy = (left_q != '0);
    assign beat = (left_q > SLOTS_L) ? SLOTS_L : left_q;

    // Purpose: load on hand-off, count down per accepted beat, hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            idx_q  <= '0;
        end else if (advance) begin
            if (busy) begin
                left_q <= left_q - beat;
                idx_q  <= idx_q + beat;
            end else if (start) begin
                left_q <= start_len;
                idx_q  <= '0;
            end
        end
    end

    // Purpose: present this beat's slot mask and running sequence numbers.
    always_comb begin
        for (int k = 0; k < SLOTS; k++) begin
            s_vld[k]            = (MLW'(k) < left_q);
            s_seq[k*MLW +: MLW] = idx_q + MLW'(k);
        end
    end

    // R6: a stalled cycle leaves the stream counter untouched
    a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> ($stable(left_q) && $stable(idx_q)));
    // R9: an accepted final beat empties the stream
    a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && advance && (left_q <= SLOTS_L)) |=> !busy);
    // R8: a full beat removes exactly SLOTS micro-ops
    a_r8_full_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && advance && (left_q > SLOTS_L)) |=> (left_q == $past(left_q) - SLOTS_L));
endmodule

// File: rtl/uop_group_steer.sv
// Module: uop_group_steer
// Top: muxes between group decode and the microcode stream, and reports
// how many window entries were consumed. Normal decode is stalled while
// the stub streams; uop_ready low freezes everything.
// Assumes: the window holds its contents until entries are popped.
module uop_group_steer
    import ugs_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int MLW   = 6,
    localparam int SRC_W = $clog2(SLOTS),
    localparam int NI_W  = $clog2(SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOTS-1:0]       q_vld,
    input  logic [SLOTS*CNT_W-1:0] q_cnt,
    input  logic [SLOTS*MLW-1:0]   q_mlen,
    output logic [NI_W-1:0]        q_pop,
    input  logic                   uop_ready,
    output logic [SLOTS-1:0]       uop_vld,
    output logic [SLOTS*SRC_W-1:0] uop_src,
    output logic [SLOTS*MLW-1:0]   uop_seq,
    output logic                   uop_ucode
);
    logic [SLOTS-1:0]       g_vld;
    logic [SLOTS*SRC_W-1:0] g_src;
    logic [SLOTS*MLW-1:0]   g_seq;
    logic [NI_W-1:0]        g_ninstr;
    logic                   g_uc;
    logic                   busy;
    logic [SLOTS-1:0]       s_vld;
    logic [SLOTS*MLW-1:0]   s_seq;

    ugs_group_former #(.SLOTS(SLOTS), .MLW(MLW)) u_form (
        .q_vld(q_vld), .q_cnt(q_cnt),
        .g_vld(g_vld), .g_src(g_src), .g_seq(g_seq),
        .g_ninstr(g_ninstr), .g_uc(g_uc)
    );

    ugs_ucode_seq #(.SLOTS(SLOTS), .MLW(MLW)) u_useq (
        .clk(clk), .rst_n(rst_n), .advance(uop_ready),
        .start(!busy && g_uc), .start_len(q_mlen[MLW-1:0]),
        .busy(busy), .s_vld(s_vld), .s_seq(s_seq)
    );

    // Purpose: choose stream or group output and the pop count.
    always_comb begin
        uop_vld   = busy ? s_vld : g_vld;
        uop_src   = busy ? '0 : g_src;
        uop_seq   = busy ? s_seq : g_seq;
        uop_ucode = busy;
        q_pop     = (uop_ready && !busy) ? g_ninstr : '0;
    end

    // R8: nothing is consumed while the stub streams
    a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q_pop == '0));
    // R10: valid slots form a prefix
    a_r10_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        ((SLOTS'(uop_vld + 1'b1) & uop_vld) == '0));
    // R5: never pop more entries than are present
    a_r5_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_pop) <= $countones(q_vld)));
    // R6: a stalled consumer pops nothing
    a_r6_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !uop_ready |-> (q_pop == '0));
    // R7: a hand-off cycle presents no slots
    a_r7_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && q_vld[0] && (int'(q_cnt[CNT_W-1:0]) >= UC_MIN)) |-> (uop_vld == '0));
endmodule

// File: tb/tb_uop_group_steer.sv
module tb_uop_group_steer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  q_vld = '0;
    logic [11:0] q_cnt = '0;
    logic [23:0] q_mlen = '0;
    logic [2:0]  q_pop;
    logic        uop_ready = 1'b1;
    logic [3:0]  uop_vld;
    logic [7:0]  uop_src;
    logic [23:0] uop_seq;
    logic        uop_ucode;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    uop_group_steer dut (
        .clk(clk), .rst_n(rst_n), .q_vld(q_vld), .q_cnt(q_cnt), .q_mlen(q_mlen),
        .q_pop(q_pop), .uop_ready(uop_ready), .uop_vld(uop_vld),
        .uop_src(uop_src), .uop_seq(uop_seq), .uop_ucode(uop_ucode)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] psrc(input int a, input int b, input int c, input int d);
        return {2'(d), 2'(c), 2'(b), 2'(a)};
    endfunction

    function automatic logic [23:0] pseq(input int a, input int b, input int c, input int d);
        return {6'(d), 6'(c), 6'(b), 6'(a)};
    endfunction

    task automatic set_e(input int i, input int c, input int l);
        q_cnt[i*3 +: 3]  = 3'(c);
        q_mlen[i*6 +: 6] = 6'(l);
    endtask

    task automatic window(input logic [3:0] v, input int c0, input int c1, input int c2, input int c3);
        q_vld = v;
        set_e(0, c0, 0); set_e(1, c1, 0); set_e(2, c2, 0); set_e(3, c3, 0);
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        window(4'b0000, 1, 1, 1, 1);
        check("R1 vld", 32'(uop_vld), 0);
        check("R1 pop", 32'(q_pop), 0);
        check("R1 ucode", 32'(uop_ucode), 0);
    endtask

    task automatic t_all_simple;
        window(4'b1111, 1, 1, 1, 1); #1;
        check("R3 simple vld", 32'(uop_vld), 4'b1111);
        check("R3 simple src", 32'(uop_src), 32'(psrc(0, 1, 2, 3)));
        check("R3 simple seq", uop_seq, pseq(0, 0, 0, 0));
        check("R5 simple pop", 32'(q_pop), 4);
        tick();
    endtask

    task automatic t_lead3;
        window(4'b1111, 3, 1, 1, 1); #1;
        check("R2 lead3 vld", 32'(uop_vld), 4'b1111);
        check("R2 lead3 src", 32'(uop_src), 32'(psrc(0, 0, 0, 1)));
        check("R2 lead3 seq", uop_seq, pseq(0, 1, 2, 0));
        check("R3 lead3 pop", 32'(q_pop), 2);
        tick();
    endtask

    task automatic t_lead4;
        window(4'b1111, 4, 1, 1, 1); #1;
        check("R2 lead4 seq", uop_seq, pseq(0, 1, 2, 3));
        check("R3 lead4 src", 32'(uop_src), 0);
        check("R3 lead4 pop", 32'(q_pop), 1);
        tick();
    endtask

    task automatic t_cut;
        window(4'b1111, 1, 2, 1, 1); #1;
        check("R4 cut vld", 32'(uop_vld), 4'b0001);
        check("R4 cut pop", 32'(q_pop), 1);
        tick();
        window(4'b1111, 2, 1, 1, 1); #1;
        check("R2 next lead src", 32'(uop_src), 32'(psrc(0, 0, 1, 2)));
        check("R2 next lead seq", uop_seq, pseq(0, 1, 0, 0));
        check("R5 next lead pop", 32'(q_pop), 3);
        tick();
        window(4'b1111, 1, 1, 7, 1); #1;
        check("R4 uc follower vld", 32'(uop_vld), 4'b0011);
        check("R4 uc follower pop", 32'(q_pop), 2);
        tick();
    endtask

    task automatic t_short;
        window(4'b0011, 1, 1, 1, 1); #1;
        check("R4 short vld", 32'(uop_vld), 4'b0011);
        check("R5 short pop", 32'(q_pop), 2);
        tick();
    endtask

    task automatic t_stall_normal;
        window(4'b1111, 1, 1, 1, 1);
        uop_ready = 1'b0; #1;
        check("R6 stall pop", 32'(q_pop), 0);
        check("R6 stall vld", 32'(uop_vld), 4'b1111);
        tick();
        check("R6 stall held", 32'(uop_vld), 4'b1111);
        uop_ready = 1'b1;
        tick();
    endtask

    task automatic t_ucode10;
        window(4'b1111, 6, 1, 1, 1);
        set_e(0, 6, 10); #1;
        check("R7 handoff vld", 32'(uop_vld), 0);
        check("R7 handoff pop", 32'(q_pop), 1);
        tick();
        window(4'b1111, 1, 1, 1, 1); #1;
        check("R8 beat0 vld", 32'(uop_vld), 4'b1111);
        check("R8 beat0 ucode", 32'(uop_ucode), 1);
        check("R8 beat0 seq", uop_seq, pseq(0, 1, 2, 3));
        check("R8 beat0 pop", 32'(q_pop), 0);
        uop_ready = 1'b0;
        tick();
        check("R6 uc stall seq", uop_seq, pseq(0, 1, 2, 3));
        uop_ready = 1'b1;
        tick();
        check("R8 beat1 seq", uop_seq, pseq(4, 5, 6, 7));
        check("R8 beat1 pop", 32'(q_pop), 0);
        tick();
        check("R8 tail vld", 32'(uop_vld), 4'b0011);
        check("R8 tail seq", 32'(uop_seq[11:0]), 32'({6'd9, 6'd8}));
        tick();
        check("R9 resume vld", 32'(uop_vld), 4'b1111);
        check("R9 resume ucode", 32'(uop_ucode), 0);
        check("R9 resume pop", 32'(q_pop), 4);
        tick();
    endtask

    task automatic t_ucode4;
        window(4'b0001, 5, 1, 1, 1);
        set_e(0, 5, 4); #1;
        check("R7 len4 pop", 32'(q_pop), 1);
        tick();
        window(4'b0011, 1, 1, 1, 1); #1;
        check("R8 len4 vld", 32'(uop_vld), 4'b1111);
        check("R8 len4 ucode", 32'(uop_ucode), 1);
        tick();
        check("R9 len4 resume vld", 32'(uop_vld), 4'b0011);
        check("R9 len4 resume pop", 32'(q_pop), 2);
        tick();
    endtask

    initial begin
        #(8 * 5000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        tick();
        t_all_simple();
        t_lead3();
        t_lead4();
        t_cut();
        t_short();
        t_stall_normal();
        t_ucode10();
        t_ucode4();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule